// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Translator

This block turns a 16-bit logical address from a CPU into a 20-bit physical address. The logical space is split into four regions by comparing the top nibble of the address against two boundaries. The first boundary is fixed at 0xE000 and opens a relocatable top window. The other two come from the two nibbles of a segment-size register and bound a stack region and a data region. Anything below both boundaries is the base region and passes through unchanged. A relocated region adds its 8-bit page register, shifted left by 12 bits, to the logical address.

Four 8-bit configuration registers (window page, stack page, data page and segment size) are loaded through a small write port and can be read back. The lookup is combinational. The physical address and a 2-bit code naming the hit region are captured into output registers on a request strobe.

Top module: `seg_xlate`

## Requirements
- R1: After reset all four configuration registers read 0, `pa` and `seg_sel` are 0, and any translated address yields `pa` equal to the logical address with its upper four bits zero.
- R2: A logical address at or above 0xE000 hits the window (`seg_sel` = 3), and `pa` = `la` + (window page << 12).
- R3: Below 0xE000, an address whose top nibble is at or above size[7:4] hits the stack region (`seg_sel` = 2), and `pa` = `la` + (stack page << 12).
- R4: Otherwise, an address whose top nibble is at or above size[3:0] hits the data region (`seg_sel` = 1), and `pa` = `la` + (data page << 12).
- R5: Otherwise the address hits the base region (`seg_sel` = 0), and `pa` = {4'h0, `la`}.
- R6: The 20-bit sum wraps modulo 2^20, so any carry out of bit 19 is dropped.
- R7: The comparison order is fixed: window first, then stack, then data, then base. This holds even when size[7:4] is at or below size[3:0], or when size[7:4] is 0xF.
- R8: A register write lands on the clock edge that samples `cfg_we`. A request sampled on that same edge is translated with the old register values.
- R9: `cfg_rdata` combinationally shows the register selected by `cfg_addr`: 0 = window page, 1 = stack page, 2 = data page, 3 = segment size.
- R10: `pa` and `seg_sel` update on the edge that samples `req` high and hold their value while `req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select for write and read-back |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| req | input | 1 | Translation request strobe |
| la | input | 16 | Logical address |
| pa | output | 20 | Registered physical address |
| seg_sel | output | 2 | Registered hit region: 0 base, 1 data, 2 stack, 3 window |

## Verification
A corrupted page register shows up directly in `pa[19:12]` on the first request that hits its region. A corrupted size nibble shows up as a wrong `seg_sel` on the first address that crosses the shifted boundary. In both cases the error is visible one clock after the request. Because the bench probes addresses exactly at each boundary and one below it, a compare that is off by one or swapped in priority flips `seg_sel` on the very next sampled result. A write that lands a cycle early or late is caught by the same-cycle request and the request that follows it.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int LA_W       = 16,
  parameter int PA_W       = 20,
  parameter int REG_W      = 8,
  parameter int PAGE_SHIFT = 12,
  parameter logic [3:0] WIN_TOP = 4'hE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             req,
  input  logic [LA_W-1:0]  la,
  output logic [PA_W-1:0]  pa,
  output logic [1:0]       seg_sel
);

  localparam logic [1:0] SEG_BASE = 2'd0;
  localparam logic [1:0] SEG_DATA = 2'd1;
  localparam logic [1:0] SEG_STK  = 2'd2;
  localparam logic [1:0] SEG_WIN  = 2'd3;

  logic [REG_W-1:0] win_pg, stk_pg, dat_pg, seg_sz;
  logic [3:0]       la_top;
  logic [1:0]       hit;
  logic [REG_W-1:0] page;
  logic [PA_W-1:0]  pa_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_pg <= '0;
      stk_pg <= '0;
      dat_pg <= '0;
      seg_sz <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: win_pg <= cfg_wdata;
        2'd1: stk_pg <= cfg_wdata;
        2'd2: dat_pg <= cfg_wdata;
        default: seg_sz <= cfg_wdata;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0: cfg_rdata = win_pg;
      2'd1: cfg_rdata = stk_pg;
      2'd2: cfg_rdata = dat_pg;
      default: cfg_rdata = seg_sz;
    endcase
  end

  assign la_top = la[LA_W-1 -: 4];

  always_comb begin
    if (la_top >= WIN_TOP)          hit = SEG_WIN;
    else if (la_top >= seg_sz[7:4]) hit = SEG_STK;
    else if (la_top >= seg_sz[3:0]) hit = SEG_DATA;
    else                            hit = SEG_BASE;
  end

  always_comb begin
    case (hit)
      SEG_WIN:  page = win_pg;
      SEG_STK:  page = stk_pg;
      SEG_DATA: page = dat_pg;
      default:  page = '0;
    endcase
  end

  assign pa_next = {{(PA_W-LA_W){1'b0}}, la}
                 + ({{(PA_W-REG_W){1'b0}}, page} << PAGE_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa      <= '0;
      seg_sel <= SEG_BASE;
    end else if (req) begin
      pa      <= pa_next;
      seg_sel <= hit;
    end
  end

  // R2
  window_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && la[LA_W-1 -: 3] == 3'b111) |=> seg_sel == SEG_WIN);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(pa) && $stable(seg_sel)));

  // R5
  base_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (seg_sel != SEG_BASE || pa == {{(PA_W-LA_W){1'b0}}, $past(la)}));

  // R6
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pa[PAGE_SHIFT-1:0] == $past(la[PAGE_SHIFT-1:0]));

  // R9
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_wdata)));

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic        req = 0;
  logic [15:0] la = 0;
  logic [19:0] pa;
  logic [1:0]  seg_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xl(input string tag, input logic [15:0] a,
                    input logic [19:0] epa, input logic [1:0] eseg);
    @(negedge clk);
    req = 1; la = a;
    @(negedge clk);
    req = 0;
    chk({tag, " pa"}, pa, epa);
    chk({tag, " seg"}, seg_sel, eseg);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      cfg_addr = i[1:0]; #1;
      chk("R1 reg reset", cfg_rdata, 0);
    end
    chk("R1 pa reset", pa, 0);
    chk("R1 seg reset", seg_sel, 0);
    @(negedge clk); req = 1; la = 16'h1234;
    @(negedge clk); req = 0;
    chk("R1 straight pa", pa, 20'h01234);
    xl("R1 window straight", 16'hE001, 20'h0E001, 2'd3);
  endtask

  task automatic t_config;
    wr(0, 8'h7F); wr(1, 8'h40); wr(2, 8'h21); wr(3, 8'hC5);
    cfg_addr = 0; #1; chk("R9 rd win", cfg_rdata, 8'h7F);
    cfg_addr = 1; #1; chk("R9 rd stk", cfg_rdata, 8'h40);
    cfg_addr = 2; #1; chk("R9 rd dat", cfg_rdata, 8'h21);
    cfg_addr = 3; #1; chk("R9 rd size", cfg_rdata, 8'hC5);
  endtask

  task automatic t_regions;
    xl("R2 window low", 16'hE123, 20'h8D123, 2'd3);
    xl("R2 window top", 16'hFFFF, 20'h8EFFF, 2'd3);
    xl("R3 stack edge", 16'hC000, 20'h4C000, 2'd2);
    xl("R3 stack top", 16'hDFFF, 20'h4DFFF, 2'd2);
    xl("R4 data top", 16'hBFFF, 20'h2CFFF, 2'd1);
    xl("R4 data edge", 16'h5000, 20'h26000, 2'd1);
    xl("R5 base top", 16'h4FFF, 20'h04FFF, 2'd0);
    xl("R5 base zero", 16'h0000, 20'h00000, 2'd0);
  endtask

  task automatic t_wrap;
    wr(0, 8'hFF);
    xl("R6 wrap", 16'hF001, 20'h0E001, 2'd3);
    wr(0, 8'h7F);
  endtask

  task automatic t_priority;
    wr(3, 8'h37);
    xl("R7 stack over data", 16'h6000, 20'h46000, 2'd2);
    xl("R7 low base", 16'h2FFF, 20'h02FFF, 2'd0);
    wr(3, 8'hF2);
    xl("R7 window over stack", 16'hE000, 20'h8D000, 2'd3);
    xl("R7 data under F", 16'hD000, 20'h2E000, 2'd1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 8'h10;
    req = 1; la = 16'hE000;
    @(negedge clk);
    cfg_we = 0; req = 0;
    chk("R8 old value used", pa, 20'h8D000);
    xl("R8 new value", 16'hE000, 20'h1E000, 2'd3);
  endtask

  task automatic t_hold;
    logic [19:0] p0;
    logic [1:0]  s0;
    p0 = pa; s0 = seg_sel;
    la = 16'h0123;
    repeat (3) @(negedge clk);
    chk("R10 hold pa", pa, p0);
    chk("R10 hold seg", seg_sel, s0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_config;
    t_regions;
    t_wrap;
    t_priority;
    t_same_cycle;
    t_hold;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule